// File: doc/BRIEF.md
# Triple-Copy SECDED Memory with Background Repair

This block is a small single-port data store meant for logic exposed to particle upsets. Each word written is first protected with a single-error-correct, double-error-detect Hamming code and then stored identically in three memory copies. A read fetches the codeword from all three copies in parallel. Each copy is decoded and corrected on its own, and the three corrected words go through a bitwise two-of-three vote. Two flags report what the read found: one for a repaired or masked fault, one for a fault that could not be repaired.

Whenever the user port is quiet and scrubbing is enabled, a background walker visits the addresses in turn. It spends one quiet cycle reading a word and the next quiet cycle writing the voted, re-encoded word back into all three copies. This clears single upsets before a second one can land in the same word. The user port always wins over the walker. A write-back is abandoned if the user port becomes active in the cycle it was due. A word that reads as unrepairable is never written back.

Top module: `tmr_ecc_mem`

## Requirements
- R1: A word written with wrEn is returned on rdData in the clock cycle after rdEn is asserted for the same address, for every 8-bit value.
- R2: A single flipped bit at any of the 13 codeword bit positions (0 to 12) in any one copy still gives correct rdData, with corrErr=1 and uncErr=0.
- R3: A read of a word whose three copies are intact gives corrErr=0 and uncErr=0.
- R4: Two flipped bits in one copy only still give correct rdData, with corrErr=1 and uncErr=0.
- R5: When two or more copies each hold a double-bit fault, uncErr=1 on the read.
- R6: When wrEn and rdEn are asserted in the same cycle, the write takes place and the read is ignored: both flags are 0 in the next cycle.
- R7: corrErr and uncErr can be 1 only in the cycle after a user read. They are 0 after reset and during idle or scrub cycles, even when the memory holds faults.
- R8: With scrubEn=1 and an idle port, every word is repaired within 2*DEPTH+4 cycles. The walker steps one address per completed write-back and wraps from the top address back to 0.
- R9: While the user port is active in every cycle, the walker neither reads nor writes, and a planted fault is still present at the next read.
- R10: With scrubEn=0, no stored word changes except by a user write.
- R11: The walker never writes back a word that decodes as uncorrectable, so a later user read still reports uncErr=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | AW | User word address |
| wrData | input | DW | User write data |
| wrEn | input | 1 | User write strobe |
| rdEn | input | 1 | User read strobe |
| scrubEn | input | 1 | Allows background repair in idle cycles |
| rdData | output | DW | Voted read data, one cycle after rdEn |
| corrErr | output | 1 | Read found a correctable fault or copy mismatch |
| uncErr | output | 1 | Read found double faults in two or more copies |

## Verification
The embedded properties check several rules on every cycle. The walker stays silent whenever the user port is active. A write-back only ever follows a walker read. The pointer steps by exactly one per write-back and holds while scrubbing is off. The flags only rise after a user read, and a fully intact read raises neither flag. Other behaviour only the bench scenarios can show, using faults planted in chosen copies: correction at every codeword position, masking by the vote, repair of planted faults by the walker across the address wrap, and the fact that an unrepairable word survives scrubbing.

// File: rtl/tmr_ecc_pkg.sv
package tmr_ecc_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic userWr;   // user write this cycle
    logic memRd;    // fetch codewords (user or walker)
    logic scrubSel; // address comes from walker pointer
    logic scrubWb;  // walker write-back of voted word
    logic rdFlag;   // flags belong to a user read
  } ctlStrobe_t;

  // number of Hamming check bits for dw data bits
  function automatic int parityBits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DW = 8,
  localparam int PB = tmr_ecc_pkg::parityBits(DW),
  localparam int NH = DW + PB,
  localparam int CW = NH + 1
) (
  input  logic [DW-1:0] dataIn,
  output logic [CW-1:0] codeOut
);

  always_comb begin
    int j;
    logic par;
    codeOut = '0;
    j = 0;
    for (int i = 1; i <= NH; i++) begin
      if ((i & (i - 1)) != 0) begin
        codeOut[i] = dataIn[j];
        j++;
      end
    end
    for (int p = 0; p < PB; p++) begin
      par = 1'b0;
      for (int i = 1; i <= NH; i++) begin
        if (i[p] && (i != (1 << p))) par = par ^ codeOut[i];
      end
      codeOut[1 << p] = par;
    end
    codeOut[0] = ^codeOut[NH:1];
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DW = 8,
  localparam int PB = tmr_ecc_pkg::parityBits(DW),
  localparam int NH = DW + PB,
  localparam int CW = NH + 1
) (
  input  logic [CW-1:0] codeIn,
  output logic [DW-1:0] dataOut,
  output logic          sglErr,
  output logic          dblErr
);

  logic [PB-1:0] syn;
  logic          allPar;
  logic [CW-1:0] fixedWord;

  always_comb begin
    syn = '0;
    for (int i = 1; i <= NH; i++) begin
      for (int p = 0; p < PB; p++) begin
        if (i[p]) syn[p] = syn[p] ^ codeIn[i];
      end
    end
    allPar = ^codeIn;
  end

  always_comb begin
    int j;
    fixedWord = codeIn;
    sglErr = allPar;
    dblErr = !allPar && (syn != '0);
    if (allPar && (syn != '0) && (int'(syn) <= NH)) fixedWord[syn] = ~codeIn[syn];
    dataOut = '0;
    j = 0;
    for (int i = 1; i <= NH; i++) begin
      if ((i & (i - 1)) != 0) begin
        dataOut[j] = fixedWord[i];
        j++;
      end
    end
  end

endmodule

// File: rtl/tmr_ecc_ctrl.sv
module tmr_ecc_ctrl
  import tmr_ecc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          scrubEn,
  output ctlStrobe_t    strobe,
  output logic [AW-1:0] scrubAddr
);

  logic          userAct;
  logic          scrubRd;
  logic          scrubWb;
  logic          pendQ;
  logic          rdFlagQ;
  logic [AW-1:0] ptrQ;

  assign userAct = wrEn | rdEn;
  assign scrubRd = scrubEn & !userAct & !pendQ;
  assign scrubWb = pendQ & !userAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= 1'b0;
      rdFlagQ <= 1'b0;
      ptrQ    <= '0;
    end else begin
      pendQ   <= scrubRd;
      rdFlagQ <= rdEn & !wrEn;
      if (scrubWb) ptrQ <= ptrQ + 1'b1;
    end
  end

  always_comb begin
    strobe.userWr   = wrEn;
    strobe.memRd    = (rdEn & !wrEn) | scrubRd;
    strobe.scrubSel = scrubRd | scrubWb;
    strobe.scrubWb  = scrubWb;
    strobe.rdFlag   = rdFlagQ;
  end

  assign scrubAddr = ptrQ;

  // R9: the walker stays silent while the user port is active
  p_user_priority_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || rdEn) |-> !strobe.scrubSel);

  // R8: a write-back is always preceded by a walker read
  p_wb_after_rd_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scrubWb |-> $past(strobe.scrubSel && !strobe.scrubWb));

  // R8: pointer steps by one after each write-back, wrapping naturally
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scrubWb |=> (scrubAddr == $past(scrubAddr) + 1'b1));

  // R10: pointer holds while scrubbing is off and nothing is pending
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!scrubEn && !pendQ) |=> $stable(scrubAddr));

endmodule

// File: rtl/tmr_ecc_dp.sv
module tmr_ecc_dp
  import tmr_ecc_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int PB    = parityBits(DW),
  localparam int CW    = DW + PB + 1,
  localparam int DEPTH = 1 << AW,
  localparam int NCOPY = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] scrubAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          corrErr,
  output logic          uncErr
);

  logic [CW-1:0] ramArr [NCOPY][DEPTH];
  logic [CW-1:0] rdWord [NCOPY];
  logic [DW-1:0] decData [NCOPY];
  logic [NCOPY-1:0] sgl;
  logic [NCOPY-1:0] dbl;

  logic [AW-1:0] memAddr;
  logic [DW-1:0] encIn;
  logic [CW-1:0] encWord;
  logic [DW-1:0] voted;
  logic          memWe;
  logic          uncNow;
  logic          mismatch;

  assign memAddr = strobe.scrubSel ? scrubAddr : addr;
  assign encIn   = strobe.scrubWb ? voted : wrData;
  assign memWe   = strobe.userWr | (strobe.scrubWb & !uncNow);

  secded_enc #(.DW(DW)) uEnc (.dataIn(encIn), .codeOut(encWord));

  always_ff @(posedge clk) begin
    if (memWe) begin
      for (int c = 0; c < NCOPY; c++) ramArr[c][memAddr] <= encWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCOPY; c++) rdWord[c] <= '0;
    end else if (strobe.memRd) begin
      for (int c = 0; c < NCOPY; c++) rdWord[c] <= ramArr[c][memAddr];
    end
  end

  for (genvar g = 0; g < NCOPY; g++) begin : gDec
    secded_dec #(.DW(DW)) uDec (
      .codeIn (rdWord[g]),
      .dataOut(decData[g]),
      .sglErr (sgl[g]),
      .dblErr (dbl[g])
    );
  end

  assign voted    = (decData[0] & decData[1]) | (decData[0] & decData[2]) |
                    (decData[1] & decData[2]);
  assign uncNow   = (dbl[0] & dbl[1]) | (dbl[0] & dbl[2]) | (dbl[1] & dbl[2]);
  assign mismatch = (rdWord[0] != rdWord[1]) || (rdWord[0] != rdWord[2]);

  assign rdData  = voted;
  assign corrErr = strobe.rdFlag & ((|sgl) | mismatch);
  assign uncErr  = strobe.rdFlag & uncNow;

  // R7: flags only belong to a user read
  p_flags_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    (corrErr || uncErr) |-> strobe.rdFlag);

  // R3: identical, fault-free copies raise no flag
  p_clean_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!mismatch && (sgl == '0) && (dbl == '0)) |-> (!corrErr && !uncErr));

  // R11: an uncorrectable word is never written back by the walker
  p_no_bad_wb_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.scrubWb && (($countones(dbl)) >= 2)) |-> (memWe == strobe.userWr));

endmodule

// File: rtl/tmr_ecc_mem.sv
module tmr_ecc_mem
  import tmr_ecc_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          scrubEn,
  output logic [DW-1:0] rdData,
  output logic          corrErr,
  output logic          uncErr
);

  ctlStrobe_t    strobe;
  logic [AW-1:0] scrubAddr;

  tmr_ecc_ctrl #(.AW(AW)) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .scrubEn  (scrubEn),
    .strobe   (strobe),
    .scrubAddr(scrubAddr)
  );

  tmr_ecc_dp #(.DW(DW), .AW(AW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .scrubAddr(scrubAddr),
    .wrData   (wrData),
    .rdData   (rdData),
    .corrErr  (corrErr),
    .uncErr   (uncErr)
  );

  // R7: a flag rises only in the cycle after a read that was not a write
  p_flag_after_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (corrErr || uncErr) |-> $past(rdEn && !wrEn));

endmodule

// File: tb/sim_tmr_ecc_mem.sv
module sim_tmr_ecc_mem;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int CW = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, scrubEn = 1'b0;
  logic [DW-1:0] rdData;
  logic corrErr, uncErr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_ecc_mem #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .scrubEn(scrubEn), .rdData(rdData), .corrErr(corrErr),
    .uncErr(uncErr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wrData = DW'(d); wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // read; outputs sampled at the negedge after the capturing edge
  task automatic doRead(input int a);
    @(negedge clk);
    addr = AW'(a); rdEn = 1'b1; wrEn = 1'b0;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic flip(input int c, input int a, input int b);
    u0.uDp.ramArr[c][a] = u0.uDp.ramArr[c][a] ^ (CW'(1) << b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(corrErr == 1'b0 && uncErr == 1'b0, "R7 reset flags", {corrErr, uncErr}, 0);
    rstN = 1'b1;

    // R1 / R3: clean write then read, sweep of values
    for (int v = 0; v < 256; v += 17) begin
      doWrite(v % DEPTH, v);
      doRead(v % DEPTH);
      chk(rdData == DW'(v), "R1 data", rdData, v);
      chk(corrErr == 1'b0 && uncErr == 1'b0, "R3 clean flags", {corrErr, uncErr}, 0);
    end

    // R2: every value, single flip at rotating position and copy
    for (int v = 0; v < 256; v++) begin
      doWrite(v % DEPTH, v);
      flip(v % 3, v % DEPTH, v % CW);
      doRead(v % DEPTH);
      chk(rdData == DW'(v) && corrErr && !uncErr, "R2 single fix",
          {rdData, corrErr, uncErr}, {v[7:0], 2'b10});
    end

    // R4: two flips in one copy
    for (int b = 0; b < CW; b++) begin
      doWrite(3, 8'hA5 ^ b);
      flip(b % 3, 3, b);
      flip(b % 3, 3, (b + 5) % CW);
      doRead(3);
      chk(rdData == (8'hA5 ^ b) && corrErr && !uncErr, "R4 double one copy",
          {rdData, corrErr, uncErr}, {8'hA5 ^ b[7:0], 2'b10});
    end

    // R5: double faults in two copies
    doWrite(4, 8'h5A);
    flip(0, 4, 1); flip(0, 4, 6);
    flip(2, 4, 3); flip(2, 4, 9);
    doRead(4);
    chk(uncErr == 1'b1, "R5 two copies double", uncErr, 1);

    // R6: write and read together, read ignored
    doWrite(9, 8'h11);
    @(negedge clk);
    addr = 4'd9; wrData = 8'hEE; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk(!corrErr && !uncErr, "R6 read ignored flags", {corrErr, uncErr}, 0);
    doRead(9);
    chk(rdData == 8'hEE, "R6 write taken", rdData, 8'hEE);

    // R10: fault persists with scrubbing off
    doWrite(5, 8'h3C);
    flip(0, 5, 3);
    repeat (2 * DEPTH + 8) @(negedge clk);
    doRead(5);
    chk(corrErr == 1'b1, "R10 no repair when off", corrErr, 1);

    // R8 + R7 + R11: scrub sweep, flags quiet during idle, bad word kept
    flip(1, 0, 7);
    flip(2, 15, 0);
    @(negedge clk);
    scrubEn = 1'b1;
    for (int k = 0; k < 2 * DEPTH + 4; k++) begin
      @(negedge clk);
      chk(!corrErr && !uncErr, "R7 idle flags", {corrErr, uncErr}, 0);
    end
    scrubEn = 1'b0;
    repeat (2) @(negedge clk);
    doRead(5);
    chk(rdData == 8'h3C && !corrErr, "R8 repaired mid", {rdData, corrErr}, {8'h3C, 1'b0});
    doRead(0);
    chk(!corrErr && !uncErr, "R8 repaired addr 0", {corrErr, uncErr}, 0);
    doRead(15);
    chk(!corrErr && !uncErr, "R8 repaired top", {corrErr, uncErr}, 0);
    doRead(4);
    chk(uncErr == 1'b1, "R11 bad word kept", uncErr, 1);

    // R9: continuous user traffic blocks the walker
    doWrite(7, 8'h77);
    flip(2, 7, 11);
    @(negedge clk);
    scrubEn = 1'b1; rdEn = 1'b1; addr = 4'd2;
    repeat (2 * DEPTH + 8) @(negedge clk);
    addr = 4'd7;
    @(negedge clk);
    rdEn = 1'b0;
    chk(rdData == 8'h77 && corrErr == 1'b1, "R9 walker blocked",
        {rdData, corrErr}, {8'h77, 1'b1});
    repeat (2 * DEPTH + 4) @(negedge clk);
    scrubEn = 1'b0;
    repeat (2) @(negedge clk);
    doRead(7);
    chk(!corrErr, "R8 repaired after traffic", corrErr, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule